// File: doc/BRIEF.md
# Banked Latency Memory Responder

The block stands in for a slow, multi-bank memory. It accepts block-read requests on a valid/ready request channel. It reads the whole block from a small internal store and parks the request in a per-bank queue with a countdown. The block comes back, with the request's tag, on a valid/ready response channel once the countdown has expired.

The low bits of the block address choose a bank. Each bank drains strictly in arrival order. A round-robin arbiter decides which bank's ready head is presented next.

Two details shape the traffic:

- **Address matching.** A request whose address is already waiting in its bank does not wait the full latency. It shares the remaining time of the older entry.
- **Stalls.** A full bank queue stalls the request channel. An optional mode also stalls it on a fixed periodic pattern.

Top module: `lat_rsp_top`

## Requirements
- R1: After reset, `rsp_valid` is 0, all bank queues are empty, `req_ready` is 1 (with the periodic stall mode off), and the last-served bank pointer is bank 0.
- R2: A request goes to bank `req_addr mod NUM_BANKS`, which is the low log2(NUM_BANKS) address bits; with 4 banks, addresses 2, 6 and 10 share bank 2.
- R3: A response carries the tag of its request and BLOCK_W/8 bytes read from byte addresses `req_addr*BYTES + j`, with byte j in bits [8j+7:8j]. The store holds the value `(a*37 + 11) mod 256` at byte address a.
- R4: With `rsp_ready` held high and no other traffic, a request handshaken in cycle t is first presented with `rsp_valid` high in cycle t+LATENCY.
- R5: Responses of one bank leave in the order their requests were accepted.
- R6: When a response is chosen, the search starts at the bank after the last-served one, wraps around, and takes the first bank whose oldest entry has expired.
- R7: A request whose address equals an entry still pending in the same bank takes over the remaining countdown of the oldest such entry. It therefore becomes eligible no later than that entry, which is sooner than LATENCY cycles after its own handshake.
- R8: `req_ready` is 0 while the addressed bank holds QUEUE_DEPTH entries. Requests to other banks are still accepted.
- R9: With STALL_EN set, `req_ready` is 0 in every cycle whose cycle count since reset c satisfies `(c/2) mod STALL_MOD == 0`. The first cycle after reset has count 0.
- R10: A presented response keeps `rsp_valid`, `rsp_data` and `rsp_tag` stable until it is accepted. If no entry is eligible after acceptance, `rsp_valid` drops.
- R11: A request transfers only in a cycle where `req_valid` and `req_ready` are both high. Address and tag values presented with `req_valid` low produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Block address of the read |
| req_tag | input | TAG_W | Tag returned with the response |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_data | output | BLOCK_W | Block read data |
| rsp_tag | output | TAG_W | Tag of the answered request |

## Verification
The bench goes after the following corner cases, each with the failure it would reveal:

- **Exact latency.** An off-by-one in the countdown load shows as a response one cycle early or late.
- **Same-bank ordering.** Swapped heads or a wrong modulus show as tags out of order.
- **Round-robin pattern.** Requests are arranged so that arbitration order differs from arrival order. An arbiter that restarts at bank 0, or forgets the last-served bank, returns the wrong tag sequence.
- **Address matching.** A duplicate address is sent a few cycles after the first. A design that reloads the full latency answers it late.
- **Full bank.** A bank is filled while a neighbour stays open. The check catches a queue that overflows, and also a stall that blocks every bank.
- **Periodic stall.** The stall pattern is compared against the bench's own cycle count.
- **Held response.** A response is held under back-pressure. Any change in its data or tag while waiting is reported.

// File: rtl/lat_rsp_pkg.sv
`timescale 1ns/1ps
package lat_rsp_pkg;

  // Content of the read-only store at one byte address.
  function automatic logic [7:0] byte_pattern(input logic [31:0] byte_addr);
    logic [31:0] mix;
    mix = byte_addr * 32'd37 + 32'd11;
    return mix[7:0];
  endfunction

  // (base + step) reduced into [0, limit) for step < limit.
  function automatic int wrap_add(input int base, input int step, input int limit);
    int sum;
    sum = base + step;
    if (sum >= limit) sum = sum - limit;
    return sum;
  endfunction

  // Countdown value for a newly queued entry.
  // A matched entry contributes its next-cycle value, so both expire together.
  function automatic int next_count(input bit hit, input int hit_cnt, input int fresh);
    if (!hit) return fresh;
    return (hit_cnt > 0) ? hit_cnt - 1 : 0;
  endfunction

endpackage

// File: rtl/lat_rsp_store.sv
`timescale 1ns/1ps
module lat_rsp_store
  import lat_rsp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4
) (
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [8*BYTES-1:0] rd_data
);
  localparam int MEM_BYTES = (1 << ADDR_W) * BYTES;
  localparam int MW        = $clog2(MEM_BYTES);

  logic [7:0] mem [MEM_BYTES];

  for (genvar g = 0; g < MEM_BYTES; g++) begin : g_cell
    assign mem[g] = byte_pattern(32'(g));
  end

  always_comb begin
    for (int j = 0; j < BYTES; j++) begin
      rd_data[8*j +: 8] = mem[MW'(int'(rd_addr) * BYTES + j)];
    end
  end
endmodule

// File: rtl/lat_rsp_bank.sv
`timescale 1ns/1ps
module lat_rsp_bank
  import lat_rsp_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int LAT    = 8,
  parameter int ADDR_W = 6,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              full,
  output logic              head_ready,
  output logic [TAG_W-1:0]  head_tag,
  output logic [DATA_W-1:0] head_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(LAT + 1);
  // The pick adds one register stage, so the countdown is loaded short by two.
  localparam int FRESH = LAT - 2;

  logic [DEPTH-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [CW-1:0]     cnt_q  [DEPTH];
  logic [PW-1:0]     rd_q, wr_q;

  logic          hit;
  logic [CW-1:0] hit_cnt;
  logic [CW-1:0] load_cnt;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return PW'(wrap_add(int'(p), 1, DEPTH));
  endfunction

  // Oldest pending entry with the same address.
  always_comb begin
    hit     = 1'b0;
    hit_cnt = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW-1:0] s;
      s = PW'(wrap_add(int'(rd_q), k, DEPTH));
      if (!hit && vld_q[s] && addr_q[s] == push_addr) begin
        hit     = 1'b1;
        hit_cnt = cnt_q[s];
      end
    end
    load_cnt = CW'(next_count(hit, int'(hit_cnt), FRESH));
  end

  assign full       = &vld_q;
  assign head_ready = vld_q[rd_q] && (cnt_q[rd_q] == '0);
  assign head_tag   = tag_q[rd_q];
  assign head_data  = data_q[rd_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (vld_q[i] && cnt_q[i] != '0) cnt_q[i] <= cnt_q[i] - 1'b1;
      end
      if (pop) begin
        vld_q[rd_q] <= 1'b0;
        rd_q        <= ptr_next(rd_q);
      end
      if (push) begin
        vld_q[wr_q]  <= 1'b1;
        tag_q[wr_q]  <= push_tag;
        addr_q[wr_q] <= push_addr;
        data_q[wr_q] <= push_data;
        cnt_q[wr_q]  <= load_cnt;
        wr_q         <= ptr_next(wr_q);
      end
    end
  end
endmodule

// File: rtl/lat_rsp_arb.sv
`timescale 1ns/1ps
module lat_rsp_arb #(
  parameter int NB = 4,
  parameter int BW = 2
) (
  input  logic [NB-1:0] elig,
  input  logic [BW-1:0] last,
  output logic          found,
  output logic [BW-1:0] pick
);
  // Search starts one past the last-served bank and wraps; NB is a power of two.
  always_comb begin
    found = 1'b0;
    pick  = last;
    for (int i = 1; i <= NB; i++) begin
      logic [BW-1:0] idx;
      idx = BW'(int'(last) + i);
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end
endmodule

// File: rtl/lat_rsp_top.sv
`timescale 1ns/1ps
module lat_rsp_top #(
  parameter int NUM_BANKS   = 4,
  parameter int QUEUE_DEPTH = 4,
  parameter int LATENCY     = 8,
  parameter int BLOCK_W     = 32,
  parameter int TAG_W       = 4,
  parameter int ADDR_W      = 6,
  parameter bit STALL_EN    = 1'b0,
  parameter int STALL_MOD   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [TAG_W-1:0]   req_tag,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [BLOCK_W-1:0] rsp_data,
  output logic [TAG_W-1:0]   rsp_tag
);
  localparam int BW    = $clog2(NUM_BANKS);
  localparam int BYTES = BLOCK_W / 8;

  // Named internal events
  logic                 req_fire, rsp_fire, full_sel, stall_tick;
  logic                 pick_found;
  logic [BW-1:0]        pick_bank, req_bank;
  logic [NUM_BANKS-1:0] bank_full, head_ready, serve_mask, elig_mask;
  logic [BLOCK_W-1:0]   rd_block;
  logic [BLOCK_W-1:0]   hd_data [NUM_BANKS];
  logic [TAG_W-1:0]     hd_tag  [NUM_BANKS];

  logic          act_q;
  logic [BW-1:0] cur_q;

  assign req_bank = req_addr[BW-1:0];

  lat_rsp_store #(.ADDR_W(ADDR_W), .BYTES(BYTES)) store_i (
    .rd_addr (req_addr),
    .rd_data (rd_block)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic push_b, pop_b;
    assign push_b = req_fire && (req_bank == BW'(b));
    assign pop_b  = rsp_fire && (cur_q == BW'(b));
    lat_rsp_bank #(
      .DEPTH(QUEUE_DEPTH), .LAT(LATENCY), .ADDR_W(ADDR_W),
      .TAG_W(TAG_W), .DATA_W(BLOCK_W)
    ) bank_i (
      .clk        (clk),
      .rst        (rst),
      .push       (push_b),
      .push_addr  (req_addr),
      .push_tag   (req_tag),
      .push_data  (rd_block),
      .pop        (pop_b),
      .full       (bank_full[b]),
      .head_ready (head_ready[b]),
      .head_tag   (hd_tag[b]),
      .head_data  (hd_data[b])
    );
  end

  if (STALL_EN) begin : g_stall
    logic [31:0] cyc_q;
    always_ff @(posedge clk) begin
      if (rst) cyc_q <= '0;
      else     cyc_q <= cyc_q + 32'd1;
    end
    assign stall_tick = ((cyc_q >> 1) % 32'(STALL_MOD)) == 32'd0;
  end else begin : g_nostall
    assign stall_tick = 1'b0;
  end

  assign full_sel  = bank_full[req_bank];
  assign req_ready = !full_sel && !stall_tick;
  assign req_fire  = req_valid && req_ready;

  assign rsp_fire   = act_q && rsp_ready;
  // The head being taken this cycle is not a candidate for the next pick.
  assign serve_mask = rsp_fire ? (NUM_BANKS'(1) << cur_q) : '0;
  assign elig_mask  = head_ready & ~serve_mask;

  lat_rsp_arb #(.NB(NUM_BANKS), .BW(BW)) arb_i (
    .elig  (elig_mask),
    .last  (cur_q),
    .found (pick_found),
    .pick  (pick_bank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cur_q <= '0;
    end else if (!act_q || rsp_fire) begin
      act_q <= pick_found;
      if (pick_found) cur_q <= pick_bank;
    end
  end

  assign rsp_valid = act_q;
  assign rsp_data  = hd_data[cur_q];
  assign rsp_tag   = hd_tag[cur_q];
endmodule

// File: rtl/lat_rsp_chk.sv
`timescale 1ns/1ps
module lat_rsp_chk #(
  parameter int NB      = 4,
  parameter int BW      = 2,
  parameter int BLOCK_W = 32,
  parameter int TAG_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [BLOCK_W-1:0] rsp_data,
  input logic [TAG_W-1:0]   rsp_tag,
  input logic [NB-1:0]      elig_mask,
  input logic               pick_found,
  input logic [BW-1:0]      pick_bank,
  input logic               full_sel,
  input logic               stall_tick
);
  // R1
  rst_idle_chk: assert property (@(posedge clk) rst |=> !rsp_valid);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_tag)));

  // R10
  idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ready && elig_mask == '0) |=> !rsp_valid);

  // R6
  rr_pick_chk: assert property (@(posedge clk) disable iff (rst)
    pick_found |-> elig_mask[pick_bank]);

  // R6
  rr_none_chk: assert property (@(posedge clk) disable iff (rst)
    (elig_mask == '0) |-> !pick_found);

  // R8
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    full_sel |-> !req_ready);

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    stall_tick |-> !req_ready);
endmodule

bind lat_rsp_top lat_rsp_chk #(
  .NB(NUM_BANKS), .BW(BW), .BLOCK_W(BLOCK_W), .TAG_W(TAG_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .rsp_tag    (rsp_tag),
  .elig_mask  (elig_mask),
  .pick_found (pick_found),
  .pick_bank  (pick_bank),
  .full_sel   (full_sel),
  .stall_tick (stall_tick)
);

// File: tb/lat_rsp_top_tb_top.sv
`timescale 1ns/1ps
module lat_rsp_top_tb_top;
  localparam int LAT   = 8;
  localparam int TW    = 4;
  localparam int DW    = 32;
  localparam int AW    = 6;
  localparam int BYTES = DW / 8;
  localparam int SMOD  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [TW-1:0] req_tag = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [TW-1:0] rsp_tag;

  logic s_req_ready, s_rsp_valid;
  logic [DW-1:0] s_rsp_data;
  logic [TW-1:0] s_rsp_tag;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int rsp_cyc [16];
  string cur_req = "R5";
  logic [TW+DW-1:0] exp_q [$];

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  lat_rsp_top #(.LATENCY(LAT), .BLOCK_W(DW), .TAG_W(TW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_tag(req_tag), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_tag(rsp_tag)
  );

  lat_rsp_top #(.LATENCY(LAT), .BLOCK_W(DW), .TAG_W(TW), .ADDR_W(AW),
                .STALL_EN(1'b1), .STALL_MOD(SMOD)) dut_stall_i (
    .clk(clk), .rst(rst), .req_valid(1'b0), .req_ready(s_req_ready),
    .req_addr('0), .req_tag('0), .rsp_valid(s_rsp_valid),
    .rsp_ready(1'b1), .rsp_data(s_rsp_data), .rsp_tag(s_rsp_tag)
  );

  // Expected block: byte a of the store is (a*37+11) mod 256, lane j from a = addr*BYTES+j.
  function automatic logic [DW-1:0] exp_block(input int addr);
    logic [DW-1:0] v;
    for (int j = 0; j < BYTES; j++) v[8*j +: 8] = 8'(((addr * BYTES + j) * 37 + 11) % 256);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input int addr, input int tag, input bit push_exp, output int hs);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = AW'(addr);
    req_tag   = TW'(tag);
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    hs = cyc;
    if (push_exp) exp_q.push_back({TW'(tag), exp_block(addr)});
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, {cur_req, " unexpected response"}, 64'(rsp_tag), 64'hffff);
      end else begin
        logic [TW+DW-1:0] e;
        e = exp_q.pop_front();
        check(rsp_tag == e[TW+DW-1:DW], {cur_req, " tag order"}, 64'(rsp_tag), 64'(e[TW+DW-1:DW]));
        check(rsp_data == e[DW-1:0], "R3 block data", 64'(rsp_data), 64'(e[DW-1:0]));
      end
      rsp_cyc[rsp_tag] = cyc;
    end
  end

  bit finished = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 64'(cyc), 64'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hs, hs_b, bad;
    logic [DW-1:0] held_d;
    logic [TW-1:0] held_t;

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check(req_ready == 1'b1, "R1 req_ready after reset", 64'(req_ready), 64'd1);

    // R11: values with req_valid low are not taken
    cur_req = "R11";
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      req_addr = AW'(i * 3 + 1);
      req_tag  = TW'(i);
    end
    bad = 0;
    repeat (LAT + 6) begin
      @(negedge clk);
      if (rsp_valid) bad++;
    end
    check(bad == 0, "R11 no response without valid", 64'(bad), 64'd0);

    // R4: exact latency, R3 data through scoreboard
    cur_req = "R4";
    send(5, 1, 1'b1, hs);
    bad = 0;
    while (!rsp_valid && bad < 60) begin
      @(negedge clk);
      bad++;
    end
    check(cyc == hs + LAT, "R4 first valid cycle", 64'(cyc - hs), 64'(LAT));
    wait_cycles(4);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 valid drops when idle", 64'(rsp_valid), 64'd0);

    // R2/R5/R10: same bank (2, 6, 10 all bank 2) plus bank 3, held under back-pressure
    cur_req = "R5";
    @(posedge clk); #1 rsp_ready = 1'b0;
    send(2, 2, 1'b0, hs);
    send(6, 3, 1'b0, hs);
    send(10, 4, 1'b0, hs);
    send(3, 5, 1'b0, hs);
    exp_q.push_back({TW'(2), exp_block(2)});
    exp_q.push_back({TW'(5), exp_block(3)});
    exp_q.push_back({TW'(3), exp_block(6)});
    exp_q.push_back({TW'(4), exp_block(10)});
    wait_cycles(LAT + 4);
    @(negedge clk);
    held_d = rsp_data;
    held_t = rsp_tag;
    check(rsp_valid && rsp_tag == TW'(2), "R5 oldest head presented", 64'(rsp_tag), 64'd2);
    bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (!rsp_valid || rsp_data != held_d || rsp_tag != held_t) bad++;
    end
    check(bad == 0, "R10 response held stable", 64'(bad), 64'd0);
    @(posedge clk); #1 rsp_ready = 1'b1;
    wait_cycles(20);
    check(exp_q.size() == 0, "R2 R5 queue drained", 64'(exp_q.size()), 64'd0);

    // R6: arbitration order differs from arrival order
    cur_req = "R6";
    @(posedge clk); #1 rsp_ready = 1'b0;
    send(1, 6, 1'b0, hs);
    send(3, 7, 1'b0, hs);
    send(4, 8, 1'b0, hs);
    send(2, 9, 1'b0, hs);
    exp_q.push_back({TW'(6), exp_block(1)});
    exp_q.push_back({TW'(9), exp_block(2)});
    exp_q.push_back({TW'(7), exp_block(3)});
    exp_q.push_back({TW'(8), exp_block(4)});
    wait_cycles(LAT + 6);
    @(posedge clk); #1 rsp_ready = 1'b1;
    wait_cycles(20);
    check(exp_q.size() == 0, "R6 round-robin drained", 64'(exp_q.size()), 64'd0);

    // R7: duplicate address inherits remaining countdown
    cur_req = "R7";
    send(9, 10, 1'b1, hs);
    wait_cycles(2);
    send(9, 11, 1'b1, hs_b);
    wait_cycles(LAT + 8);
    check(rsp_cyc[11] < hs_b + LAT, "R7 matched request early", 64'(rsp_cyc[11] - hs_b), 64'(LAT - 1));
    check(exp_q.size() == 0, "R7 both answered", 64'(exp_q.size()), 64'd0);

    // R8: full bank 0 blocks only bank 0
    cur_req = "R8";
    @(posedge clk); #1 rsp_ready = 1'b0;
    send(0, 12, 1'b0, hs);
    send(4, 13, 1'b0, hs);
    send(8, 14, 1'b0, hs);
    send(12, 15, 1'b0, hs);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = AW'(16);
    req_tag   = TW'(0);
    bad = 0;
    repeat (4) begin
      @(negedge clk);
      if (req_ready) bad++;
    end
    check(bad == 0, "R8 full bank stalls", 64'(bad), 64'd0);
    @(posedge clk); #1;
    req_addr = AW'(1);
    req_tag  = TW'(1);
    @(negedge clk);
    check(req_ready == 1'b1, "R8 other bank accepted", 64'(req_ready), 64'd1);
    @(posedge clk); #1 req_valid = 1'b0;
    exp_q.push_back({TW'(12), exp_block(0)});
    exp_q.push_back({TW'(1),  exp_block(1)});
    exp_q.push_back({TW'(13), exp_block(4)});
    exp_q.push_back({TW'(14), exp_block(8)});
    exp_q.push_back({TW'(15), exp_block(12)});
    wait_cycles(LAT + 6);
    @(posedge clk); #1 rsp_ready = 1'b1;
    wait_cycles(24);
    check(exp_q.size() == 0, "R8 drained", 64'(exp_q.size()), 64'd0);
    req_addr = AW'(16);
    @(negedge clk);
    check(req_ready == 1'b1, "R8 ready after drain", 64'(req_ready), 64'd1);

    // R9: periodic stall pattern on the second instance
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (s_req_ready != !(((cyc / 2) % SMOD) == 0)) bad++;
    end
    check(bad == 0, "R9 stall pattern", 64'(bad), 64'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule